// File: doc/BRIEF.md
# Two-Level Loop DMA Sequencer

This block runs one transfer descriptor for a single DMA channel. Software loads the descriptor in one cycle while the channel is idle. The descriptor holds the start addresses, the signed per-access steps, the access sizes, the address wrap windows, the bytes per inner pass, the iteration count and the end-of-run adjustments. Each service request, from software or from hardware, runs one inner pass. An inner pass is a series of elements. An element is read from the source in source-sized accesses, held in a local buffer and written out in destination-sized accesses. Each access is a request held until acknowledged on a simple memory port.

Each inner pass decrements the iteration count. When the last iteration finishes, the addresses receive their end-of-run adjustments, the count reloads and a done flag is raised. Per pass, the block can also raise interrupt pulses, pulse a trigger for another channel and throttle its own bus use with idle gaps after each access.

Top module: `dma_loop_engine`

## Requirements
- R1: After synchronous reset the block is idle: busy, req_en, done, both request lines and all pulse outputs are 0.
- R2: When idle, a sw_start pulse runs exactly one inner pass. hw_req also runs one pass, but only while req_en is 1. hw_req with req_en at 0 starts nothing and leaves every address and the count unchanged. req_en_set sets req_en.
- R3: Size codes 0 to 5 mean 1, 2, 4, 8, 16 and 32 bytes. An element is as large as the larger of the two sizes. It is read in source-sized accesses and written in destination-sized accesses, and the bytes keep their order. Read and write are never requested together.
- R4: After each read the sign-extended 16-bit source step is added to the source address. After each write the destination step is added to the destination address. An address is held stable while its request waits for its acknowledge.
- R5: A non-zero wrap field n keeps the updated address inside its aligned 2^n-byte window: the low n bits take the sum and the upper bits keep their old value. A field of 0 means no wrap.
- R6: An inner pass moves cfg_minor_bytes bytes, which must be a multiple of the element size. iter_now then drops by one.
- R7: On the pass that ends the last iteration, the signed last-adjust values are added to both addresses, iter_now reloads the loaded count and done is set. done clears on the next start or load.
- R8: After a pass that is not the last, the signed loop offset is added to the source address when its enable is set and to the destination address when its enable is set. On the last pass it is not added.
- R9: A bandwidth code of 2 inserts 4 idle cycles after each access and code 3 inserts 8. Codes 0 and 1 insert none.
- R10: Link mode 1 pulses link_pulse after every pass. Mode 2 pulses it only after the last pass. Modes 0 and 3 never pulse it. link_chan shows the loaded target channel.
- R11: irq_major pulses with the last pass when its enable is set. irq_half pulses when its enable is set, the loaded count is at least 2 and the decremented count equals half of the loaded count, rounded down.
- R12: With auto-stop set, req_en clears when the last pass completes. With auto-stop clear, req_en keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_load | input | 1 | Latch the cfg_* descriptor (only while idle) |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_step | input | 16 | Signed source step per read |
| cfg_dst_step | input | 16 | Signed destination step per write |
| cfg_src_size | input | 3 | Source size code |
| cfg_dst_size | input | 3 | Destination size code |
| cfg_src_mod | input | 5 | Source wrap window log2, 0 = off |
| cfg_dst_mod | input | 5 | Destination wrap window log2, 0 = off |
| cfg_minor_bytes | input | NBW | Bytes per inner pass |
| cfg_iter | input | CW | Iteration count, at least 1 |
| cfg_src_last | input | AW | Signed source end-of-run adjustment |
| cfg_dst_last | input | AW | Signed destination end-of-run adjustment |
| cfg_loop_ofs | input | AW | Signed per-pass loop offset |
| cfg_loop_ofs_src_en | input | 1 | Apply loop offset to source |
| cfg_loop_ofs_dst_en | input | 1 | Apply loop offset to destination |
| cfg_bw | input | 2 | Bandwidth throttle code |
| cfg_link_mode | input | 2 | 0 none, 1 every pass, 2 last pass, 3 none |
| cfg_link_chan | input | LCW | Linked channel number |
| cfg_irq_major_en | input | 1 | Enable irq_major |
| cfg_irq_half_en | input | 1 | Enable irq_half |
| cfg_auto_stop | input | 1 | Clear req_en at end of run |
| req_en_set | input | 1 | Set the hardware request enable |
| hw_req | input | 1 | Hardware service request |
| sw_start | input | 1 | Software start pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_size | output | 3 | Read size code |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 8<<MAX_LG | Read data, low bytes used |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_size | output | 3 | Write size code |
| wr_data | output | 8<<MAX_LG | Write data, low bytes valid |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | A pass is in progress |
| req_en | output | 1 | Hardware request enable |
| done | output | 1 | Last iteration completed |
| irq_major | output | 1 | End-of-run interrupt pulse |
| irq_half | output | 1 | Half-way interrupt pulse |
| link_pulse | output | 1 | Channel-link trigger pulse |
| link_chan | output | LCW | Linked channel number |
| src_now | output | AW | Current source address |
| dst_now | output | AW | Current destination address |
| iter_now | output | CW | Current iteration count |

## Verification
The first descriptor uses equal 4-byte sizes, plain steps and a per-pass link, and confirms the basic stepping, the count-down and the half and end-of-run events. A byte-source, word-destination run with a negative destination step, loop offsets and a 4-cycle throttle separates element packing and sign extension from the offset rules and the idle-gap count. A wrapped source started near the top of its 16-byte window, run from hardware requests with auto-stop and an 8-cycle throttle, separates modulo arithmetic from plain addition and shows the later hw_req being ignored. A 32-byte run with code 1 and link mode 3 shows the non-throttling and non-linking codes, with the half event disabled.

// File: rtl/dle_pkg.sv
package dle_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_STALL,
    ST_FINISH
  } dle_state_e;

  localparam logic [1:0] LINK_OFF   = 2'd0;
  localparam logic [1:0] LINK_EVERY = 2'd1;
  localparam logic [1:0] LINK_LAST  = 2'd2;

  // Idle cycles inserted after each access for a bandwidth code.
  function automatic logic [3:0] stall_cycles(input logic [1:0] code);
    case (code)
      2'd2:    return 4'd4;
      2'd3:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/dle_wrap_add.sv
module dle_wrap_add #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] delta,
  input  logic [4:0]    win_lg,
  output logic [AW-1:0] result
);
  logic [AW-1:0] sum;
  logic [AW-1:0] low_mask;

  always_comb begin
    sum      = base + delta;
    low_mask = (AW'(1) << win_lg) - AW'(1);
    if (win_lg == 5'd0) result = sum;
    else                result = (base & ~low_mask) | (sum & low_mask);
  end
endmodule

// File: rtl/dle_stall.sv
module dle_stall (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] len,
  output logic       last
);
  logic [3:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= len;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 4'd1;
  end

  assign last = (cnt_q == 4'd1);
endmodule

// File: rtl/dle_iter.sv
module dle_iter #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] count_in,
  input  logic          step,
  output logic [CW-1:0] citer,
  output logic          at_last,
  output logic          half_next
);
  logic [CW-1:0] biter_q;
  logic [CW-1:0] citer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      biter_q <= '0;
      citer_q <= '0;
    end else if (load) begin
      biter_q <= count_in;
      citer_q <= count_in;
    end else if (step) begin
      citer_q <= at_last ? biter_q : citer_q - CW'(1);
    end
  end

  assign citer     = citer_q;
  assign at_last   = (citer_q == CW'(1));
  assign half_next = (biter_q >= CW'(2)) && !at_last &&
                     ((citer_q - CW'(1)) == (biter_q >> 1));
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
  import dle_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 15,
  parameter int NBW    = 16,
  parameter int MAX_LG = 5,
  parameter int LCW    = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   desc_load,
  input  logic [AW-1:0]          cfg_src_addr,
  input  logic [AW-1:0]          cfg_dst_addr,
  input  logic [15:0]            cfg_src_step,
  input  logic [15:0]            cfg_dst_step,
  input  logic [2:0]             cfg_src_size,
  input  logic [2:0]             cfg_dst_size,
  input  logic [4:0]             cfg_src_mod,
  input  logic [4:0]             cfg_dst_mod,
  input  logic [NBW-1:0]         cfg_minor_bytes,
  input  logic [CW-1:0]          cfg_iter,
  input  logic [AW-1:0]          cfg_src_last,
  input  logic [AW-1:0]          cfg_dst_last,
  input  logic [AW-1:0]          cfg_loop_ofs,
  input  logic                   cfg_loop_ofs_src_en,
  input  logic                   cfg_loop_ofs_dst_en,
  input  logic [1:0]             cfg_bw,
  input  logic [1:0]             cfg_link_mode,
  input  logic [LCW-1:0]         cfg_link_chan,
  input  logic                   cfg_irq_major_en,
  input  logic                   cfg_irq_half_en,
  input  logic                   cfg_auto_stop,
  input  logic                   req_en_set,
  input  logic                   hw_req,
  input  logic                   sw_start,
  output logic                   rd_req,
  output logic [AW-1:0]          rd_addr,
  output logic [2:0]             rd_size,
  input  logic                   rd_ack,
  input  logic [(8<<MAX_LG)-1:0] rd_data,
  output logic                   wr_req,
  output logic [AW-1:0]          wr_addr,
  output logic [2:0]             wr_size,
  output logic [(8<<MAX_LG)-1:0] wr_data,
  input  logic                   wr_ack,
  output logic                   busy,
  output logic                   req_en,
  output logic                   done,
  output logic                   irq_major,
  output logic                   irq_half,
  output logic                   link_pulse,
  output logic [LCW-1:0]         link_chan,
  output logic [AW-1:0]          src_now,
  output logic [AW-1:0]          dst_now,
  output logic [CW-1:0]          iter_now
);
  localparam int DW = 8 << MAX_LG;
  localparam int BW = MAX_LG + 1;   // beat counter width

  dle_state_e state_q, after_q, nxt;

  // Latched descriptor
  logic [2:0]     ssz_q, dsz_q;
  logic [15:0]    sstep_q, dstep_q;
  logic [4:0]     smod_q, dmod_q;
  logic [NBW-1:0] nbytes_q;
  logic [AW-1:0]  slast_q, dlast_q, lofs_q;
  logic           lofs_s_q, lofs_d_q, ime_q, ihe_q, astop_q;
  logic [1:0]     bw_q, lmode_q;
  logic [LCW-1:0] lchan_q;

  // Working state
  logic [AW-1:0]  src_q, dst_q;
  logic [NBW-1:0] left_q;
  logic [BW-1:0]  beat_q;
  logic [DW-1:0]  buf_q;
  logic           done_q, irqm_q, irqh_q, link_q, reqen_q;

  logic [2:0]     el_lg;
  logic [NBW-1:0] el_bytes;
  logic [BW-1:0]  rd_last_beat, wr_last_beat;
  logic [AW-1:0]  src_nx, dst_nx;
  logic [DW-1:0]  rd_mask, rd_merge;
  int unsigned    rd_shift, wr_shift;
  logic           acc_done, go, iter_load, iter_step, at_last, half_next;
  logic [3:0]     stall_len;
  logic           stall_last;
  logic [CW-1:0]  citer;

  always_comb begin
    el_lg        = (ssz_q > dsz_q) ? ssz_q : dsz_q;
    el_bytes     = NBW'(1) << el_lg;
    rd_last_beat = (BW'(1) << (el_lg - ssz_q)) - BW'(1);
    wr_last_beat = (BW'(1) << (el_lg - dsz_q)) - BW'(1);
    rd_mask      = {DW{1'b1}} >> (DW - (8 << ssz_q));
    rd_shift     = 32'(beat_q) * (32'd8 << ssz_q);
    wr_shift     = 32'(beat_q) * (32'd8 << dsz_q);
    rd_merge     = buf_q | ((rd_data & rd_mask) << rd_shift);
  end

  assign stall_len = stall_cycles(bw_q);
  assign acc_done  = (state_q == ST_READ && rd_ack) || (state_q == ST_WRITE && wr_ack);
  assign go        = sw_start || (hw_req && reqen_q);
  assign iter_load = (state_q == ST_IDLE) && desc_load;
  assign iter_step = (state_q == ST_FINISH);

  dle_wrap_add #(.AW(AW)) u_src_wrap (
    .base   (src_q),
    .delta  ({{(AW-16){sstep_q[15]}}, sstep_q}),
    .win_lg (smod_q),
    .result (src_nx)
  );

  dle_wrap_add #(.AW(AW)) u_dst_wrap (
    .base   (dst_q),
    .delta  ({{(AW-16){dstep_q[15]}}, dstep_q}),
    .win_lg (dmod_q),
    .result (dst_nx)
  );

  dle_stall u_stall (
    .clk  (clk),
    .rst  (rst),
    .load (acc_done && (stall_len != 4'd0)),
    .len  (stall_len),
    .last (stall_last)
  );

  dle_iter #(.CW(CW)) u_iter (
    .clk       (clk),
    .rst       (rst),
    .load      (iter_load),
    .count_in  (cfg_iter),
    .step      (iter_step),
    .citer     (citer),
    .at_last   (at_last),
    .half_next (half_next)
  );

  // Next state after a completed access
  always_comb begin
    nxt = state_q;
    if (state_q == ST_READ) begin
      nxt = (beat_q == rd_last_beat) ? ST_WRITE : ST_READ;
    end else if (state_q == ST_WRITE) begin
      if (beat_q != wr_last_beat)    nxt = ST_WRITE;
      else if (left_q == el_bytes)   nxt = ST_FINISH;
      else                           nxt = ST_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      after_q  <= ST_IDLE;
      ssz_q    <= '0;  dsz_q   <= '0;
      sstep_q  <= '0;  dstep_q <= '0;
      smod_q   <= '0;  dmod_q  <= '0;
      nbytes_q <= '0;
      slast_q  <= '0;  dlast_q <= '0;  lofs_q <= '0;
      lofs_s_q <= 1'b0; lofs_d_q <= 1'b0;
      ime_q    <= 1'b0; ihe_q    <= 1'b0; astop_q <= 1'b0;
      bw_q     <= '0;  lmode_q <= '0;  lchan_q <= '0;
      src_q    <= '0;  dst_q   <= '0;
      left_q   <= '0;  beat_q  <= '0;  buf_q   <= '0;
      done_q   <= 1'b0;
      irqm_q   <= 1'b0; irqh_q   <= 1'b0; link_q  <= 1'b0;
    end else begin
      irqm_q <= 1'b0;
      irqh_q <= 1'b0;
      link_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (desc_load) begin
            ssz_q    <= cfg_src_size;  dsz_q   <= cfg_dst_size;
            sstep_q  <= cfg_src_step;  dstep_q <= cfg_dst_step;
            smod_q   <= cfg_src_mod;   dmod_q  <= cfg_dst_mod;
            nbytes_q <= cfg_minor_bytes;
            slast_q  <= cfg_src_last;  dlast_q <= cfg_dst_last;
            lofs_q   <= cfg_loop_ofs;
            lofs_s_q <= cfg_loop_ofs_src_en;
            lofs_d_q <= cfg_loop_ofs_dst_en;
            ime_q    <= cfg_irq_major_en;
            ihe_q    <= cfg_irq_half_en;
            astop_q  <= cfg_auto_stop;
            bw_q     <= cfg_bw;
            lmode_q  <= cfg_link_mode;
            lchan_q  <= cfg_link_chan;
            src_q    <= cfg_src_addr;
            dst_q    <= cfg_dst_addr;
            done_q   <= 1'b0;
          end else if (go) begin
            state_q <= ST_READ;
            left_q  <= nbytes_q;
            beat_q  <= '0;
            buf_q   <= '0;
            done_q  <= 1'b0;
          end
        end
        ST_READ, ST_WRITE: begin
          if (acc_done) begin
            if (state_q == ST_READ) begin
              buf_q <= rd_merge;
              src_q <= src_nx;
            end else begin
              dst_q <= dst_nx;
            end
            if (nxt == state_q) begin
              beat_q <= beat_q + BW'(1);
            end else begin
              beat_q <= '0;
            end
            if (state_q == ST_WRITE && beat_q == wr_last_beat) begin
              left_q <= left_q - el_bytes;
              buf_q  <= '0;
            end
            if (stall_len != 4'd0) begin
              state_q <= ST_STALL;
              after_q <= nxt;
            end else begin
              state_q <= nxt;
            end
          end
        end
        ST_STALL: begin
          if (stall_last) state_q <= after_q;
        end
        ST_FINISH: begin
          state_q <= ST_IDLE;
          if (at_last) begin
            src_q  <= src_q + slast_q;
            dst_q  <= dst_q + dlast_q;
            done_q <= 1'b1;
            irqm_q <= ime_q;
            link_q <= (lmode_q == LINK_EVERY) || (lmode_q == LINK_LAST);
          end else begin
            if (lofs_s_q) src_q <= src_q + lofs_q;
            if (lofs_d_q) dst_q <= dst_q + lofs_q;
            irqh_q <= ihe_q && half_next;
            link_q <= (lmode_q == LINK_EVERY);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Hardware request enable: set by software, cleared by auto-stop
  always_ff @(posedge clk) begin
    if (rst)                                              reqen_q <= 1'b0;
    else if (state_q == ST_FINISH && at_last && astop_q)  reqen_q <= 1'b0;
    else if (req_en_set)                                  reqen_q <= 1'b1;
  end

  assign rd_req     = (state_q == ST_READ);
  assign rd_addr    = src_q;
  assign rd_size    = ssz_q;
  assign wr_req     = (state_q == ST_WRITE);
  assign wr_addr    = dst_q;
  assign wr_size    = dsz_q;
  assign wr_data    = buf_q >> wr_shift;
  assign busy       = (state_q != ST_IDLE);
  assign req_en     = reqen_q;
  assign done       = done_q;
  assign irq_major  = irqm_q;
  assign irq_half   = irqh_q;
  assign link_pulse = link_q;
  assign link_chan  = lchan_q;
  assign src_now    = src_q;
  assign dst_now    = dst_q;
  assign iter_now   = citer;
endmodule

// File: rtl/dle_checker.sv
module dle_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          sw_start,
  input logic          hw_req,
  input logic          req_en,
  input logic          busy,
  input logic          done,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic          irq_major
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: one cycle after a reset edge everything is quiet
  always @(negedge clk) begin
    if (rst_seen) begin
      p_reset_quiet_r1: assert (!busy && !req_en && !done && !rd_req && !wr_req && !irq_major)
        else $error("R1 reset state");
    end
  end

  p_idle_no_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !sw_start && !(hw_req && req_en)) |=> !busy);

  p_one_access_r3: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr)));

  p_major_irq_done_r11: assert property (@(posedge clk) disable iff (rst)
    irq_major |-> done);

  p_autostop_done_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(req_en) |-> done);
endmodule

bind dma_loop_engine dle_checker #(.AW(AW)) u_dle_checker (
  .clk       (clk),
  .rst       (rst),
  .sw_start  (sw_start),
  .hw_req    (hw_req),
  .req_en    (req_en),
  .busy      (busy),
  .done      (done),
  .rd_req    (rd_req),
  .rd_ack    (rd_ack),
  .rd_addr   (rd_addr),
  .wr_req    (wr_req),
  .wr_ack    (wr_ack),
  .wr_addr   (wr_addr),
  .irq_major (irq_major)
);

// File: tb/dma_loop_engine_tb_top.sv
module dma_loop_engine_tb_top;
  localparam int AW = 32, CW = 15, NBW = 16, MAX_LG = 5, LCW = 5;
  localparam int DW = 8 << MAX_LG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  // Descriptor and control drives
  logic           desc_load = 0, req_en_set = 0, hw_req = 0, sw_start = 0;
  logic [AW-1:0]  d_src = 0, d_dst = 0, d_slast = 0, d_dlast = 0, d_lofs = 0;
  logic [15:0]    d_sstep = 0, d_dstep = 0;
  logic [2:0]     d_ssz = 0, d_dsz = 0;
  logic [4:0]     d_smod = 0, d_dmod = 0;
  logic [NBW-1:0] d_nbytes = 0;
  logic [CW-1:0]  d_iter = 1;
  logic           d_lofs_s = 0, d_lofs_d = 0, d_ime = 0, d_ihe = 0, d_astop = 0;
  logic [1:0]     d_bw = 0, d_lmode = 0;
  logic [LCW-1:0] d_lchan = 0;

  logic           rd_req, rd_ack = 0, wr_req, wr_ack = 0;
  logic [AW-1:0]  rd_addr, wr_addr, src_now, dst_now;
  logic [2:0]     rd_size, wr_size;
  logic [DW-1:0]  rd_data = '0, wr_data;
  logic           busy, req_en, done, irq_major, irq_half, link_pulse;
  logic [LCW-1:0] link_chan;
  logic [CW-1:0]  iter_now;

  dma_loop_engine #(.AW(AW), .CW(CW), .NBW(NBW), .MAX_LG(MAX_LG), .LCW(LCW)) dut_i (
    .clk(clk), .rst(rst), .desc_load(desc_load),
    .cfg_src_addr(d_src), .cfg_dst_addr(d_dst),
    .cfg_src_step(d_sstep), .cfg_dst_step(d_dstep),
    .cfg_src_size(d_ssz), .cfg_dst_size(d_dsz),
    .cfg_src_mod(d_smod), .cfg_dst_mod(d_dmod),
    .cfg_minor_bytes(d_nbytes), .cfg_iter(d_iter),
    .cfg_src_last(d_slast), .cfg_dst_last(d_dlast), .cfg_loop_ofs(d_lofs),
    .cfg_loop_ofs_src_en(d_lofs_s), .cfg_loop_ofs_dst_en(d_lofs_d),
    .cfg_bw(d_bw), .cfg_link_mode(d_lmode), .cfg_link_chan(d_lchan),
    .cfg_irq_major_en(d_ime), .cfg_irq_half_en(d_ihe), .cfg_auto_stop(d_astop),
    .req_en_set(req_en_set), .hw_req(hw_req), .sw_start(sw_start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .req_en(req_en), .done(done), .irq_major(irq_major), .irq_half(irq_half),
    .link_pulse(link_pulse), .link_chan(link_chan),
    .src_now(src_now), .dst_now(dst_now), .iter_now(iter_now)
  );

  int tests = 0, fails = 0, cyc = 0;

  typedef struct {
    bit            is_wr;
    logic [AW-1:0] addr;
    logic [2:0]    size;
    logic [DW-1:0] data;
    bit            first;
  } item_t;
  item_t exp_q[$];

  // Reference model state
  logic [AW-1:0] m_src, m_dst;
  logic [CW-1:0] m_iter;
  bit e_major, e_half, e_link;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h5C;
  endfunction

  function automatic logic [AW-1:0] wrap_ref(input logic [AW-1:0] old_a,
                                             input logic [AW-1:0] delta,
                                             input logic [4:0] n);
    longint unsigned win, o, s;
    logic [AW-1:0] sum;
    sum = old_a + delta;
    if (n == 0) return sum;
    win = 64'd1 << n;
    o = 64'(old_a);
    s = 64'(sum);
    return AW'(o - (o % win) + (s % win));
  endfunction

  function automatic int gap_ref(input logic [1:0] code);
    return (code == 2'd2) ? 4 : (code == 2'd3) ? 8 : 0;
  endfunction

  // Driver side: push the expected accesses of one inner pass
  task automatic predict_pass();
    int lg, el, nel;
    logic [DW-1:0] buf_v;
    item_t it;
    lg  = (d_ssz > d_dsz) ? int'(d_ssz) : int'(d_dsz);
    el  = 1 << lg;
    nel = int'(d_nbytes) / el;
    for (int e = 0; e < nel; e++) begin
      buf_v = '0;
      for (int r = 0; r < (el >> d_ssz); r++) begin
        it = '{is_wr: 1'b0, addr: m_src, size: d_ssz, data: '0, first: (e == 0 && r == 0)};
        exp_q.push_back(it);
        for (int k = 0; k < (1 << d_ssz); k++)
          buf_v[(r * (1 << d_ssz) + k) * 8 +: 8] = mem_byte(m_src + AW'(k));
        m_src = wrap_ref(m_src, {{16{d_sstep[15]}}, d_sstep}, d_smod);
      end
      for (int w = 0; w < (el >> d_dsz); w++) begin
        it = '{is_wr: 1'b1, addr: m_dst, size: d_dsz,
               data: buf_v >> (w * (1 << d_dsz) * 8), first: 1'b0};
        exp_q.push_back(it);
        m_dst = wrap_ref(m_dst, {{16{d_dstep[15]}}, d_dstep}, d_dmod);
      end
    end
    e_major = (m_iter == 1);
    if (e_major) begin
      m_src  = m_src + d_slast;
      m_dst  = m_dst + d_dlast;
      m_iter = d_iter;
      e_half = 1'b0;
    end else begin
      if (d_lofs_s) m_src = m_src + d_lofs;
      if (d_lofs_d) m_dst = m_dst + d_lofs;
      m_iter = m_iter - 1;
      e_half = d_ihe && (d_iter >= 2) && (m_iter == (d_iter >> 1));
    end
    e_link = (d_lmode == 2'd1) || (d_lmode == 2'd2 && e_major);
  endtask

  // Monitor and memory responder (one process, negedge)
  int idle_cnt = 0;
  always @(negedge clk) begin
    item_t it;
    logic [DW-1:0] rd_v;
    bit data_ok;
    if (!rst && (rd_req || wr_req) && !(rd_ack || wr_ack)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected access", {32'd0, rd_req ? rd_addr : wr_addr}, 64'd0);
      end else begin
        it = exp_q.pop_front();
        check(it.is_wr == wr_req, "R3", "access kind", 64'(wr_req), 64'(it.is_wr));
        check((wr_req ? wr_addr : rd_addr) == it.addr, "R4/R5", "access address",
              64'(wr_req ? wr_addr : rd_addr), 64'(it.addr));
        check((wr_req ? wr_size : rd_size) == it.size, "R3", "access size",
              64'(wr_req ? wr_size : rd_size), 64'(it.size));
        if (wr_req) begin
          data_ok = 1'b1;
          for (int k = 0; k < (1 << it.size); k++)
            if (wr_data[k*8 +: 8] !== it.data[k*8 +: 8]) data_ok = 1'b0;
          check(data_ok, "R3", "write data low bytes", wr_data[63:0], it.data[63:0]);
        end
        if (!it.first)
          check(idle_cnt == gap_ref(d_bw), "R9", "idle gap", 64'(idle_cnt), 64'(gap_ref(d_bw)));
      end
      idle_cnt = 0;
      if (rd_req) begin
        rd_v = {DW{1'b1}} ^ {DW{1'b1}};
        for (int k = 0; k < DW / 8; k++)
          rd_v[k*8 +: 8] = (k < (1 << rd_size)) ? mem_byte(rd_addr + AW'(k)) : 8'hEE;
        rd_data <= rd_v;
        rd_ack  <= 1'b1;
      end else begin
        wr_ack <= 1'b1;
      end
    end else begin
      if (busy && !rd_req && !wr_req) idle_cnt++;
      rd_ack <= 1'b0;
      wr_ack <= 1'b0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic load_desc();
    @(negedge clk) desc_load = 1'b1;
    @(negedge clk) desc_load = 1'b0;
    m_src = d_src; m_dst = d_dst; m_iter = d_iter;
    check(iter_now == d_iter, "R7", "count after load", 64'(iter_now), 64'(d_iter));
    check(!done, "R7", "done clear after load", 64'(done), 64'd0);
    check(link_chan == d_lchan, "R10", "link channel", 64'(link_chan), 64'(d_lchan));
  endtask

  task automatic run_pass(input bit use_hw, input logic exp_req_en);
    int n;
    predict_pass();
    @(negedge clk);
    if (use_hw) hw_req = 1'b1; else sw_start = 1'b1;
    @(negedge clk);
    hw_req = 1'b0; sw_start = 1'b0;
    check(busy, "R2", "busy after start", 64'(busy), 64'd1);
    n = 0;
    while (busy && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(!busy, "R6", "pass finished", 64'(busy), 64'd0);
    check(exp_q.size() == 0, "R6", "all accesses issued", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    check(iter_now == m_iter, "R6", "iteration count", 64'(iter_now), 64'(m_iter));
    check(src_now == m_src, "R8", "source after pass", 64'(src_now), 64'(m_src));
    check(dst_now == m_dst, "R8", "destination after pass", 64'(dst_now), 64'(m_dst));
    check(done == e_major, "R7", "done flag", 64'(done), 64'(e_major));
    check(irq_major == (e_major && d_ime), "R11", "major irq", 64'(irq_major), 64'(e_major && d_ime));
    check(irq_half == e_half, "R11", "half irq", 64'(irq_half), 64'(e_half));
    check(link_pulse == e_link, "R10", "link pulse", 64'(link_pulse), 64'(e_link));
    check(req_en == exp_req_en, "R12", "request enable", 64'(req_en), 64'(exp_req_en));
    @(negedge clk);
    check(!link_pulse && !irq_major && !irq_half, "R10", "pulses one cycle",
          64'({link_pulse, irq_major, irq_half}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !req_en && !done && !rd_req && !wr_req, "R1", "reset outputs",
          64'({busy, req_en, done, rd_req, wr_req}), 64'd0);
    check(!irq_major && !irq_half && !link_pulse, "R1", "reset pulses",
          64'({irq_major, irq_half, link_pulse}), 64'd0);

    // Case A: equal 4-byte sizes, link every pass, half and major events
    d_src = 32'h0000_1000; d_dst = 32'h0000_2000; d_sstep = 16'd4; d_dstep = 16'd4;
    d_ssz = 3'd2; d_dsz = 3'd2; d_nbytes = 16'd8; d_iter = 15'd3;
    d_slast = -32'sd24; d_dlast = 32'd16; d_lmode = 2'd1; d_lchan = 5'd7;
    d_ime = 1'b1; d_ihe = 1'b1; d_bw = 2'd0;
    load_desc();
    @(negedge clk) req_en_set = 1'b1;
    @(negedge clk) req_en_set = 1'b0;
    run_pass(1'b0, 1'b1);   // R2 software start
    run_pass(1'b1, 1'b1);   // R2 hardware start, half event (R11)
    run_pass(1'b0, 1'b1);   // R7 last pass, auto-stop off keeps R12 enable

    // Case B: byte source into word destination, negative step, loop offsets, 4-cycle throttle
    d_src = 32'h0000_3001; d_dst = 32'h0000_4040; d_sstep = 16'd1; d_dstep = 16'hFFFC;
    d_ssz = 3'd0; d_dsz = 3'd2; d_nbytes = 16'd8; d_iter = 15'd2;
    d_lofs = 32'h0000_0100; d_lofs_s = 1'b1; d_lofs_d = 1'b1;
    d_slast = 32'd0; d_dlast = -32'sd64; d_lmode = 2'd2; d_lchan = 5'd3;
    d_ime = 1'b0; d_ihe = 1'b0; d_bw = 2'd2;
    load_desc();
    run_pass(1'b0, 1'b1);   // R8 offsets applied, R10 no link mid-run
    run_pass(1'b0, 1'b1);   // R8 offsets skipped at end, R10 link at end

    // Case C: wrapped source, hardware requests with auto-stop, 8-cycle throttle
    d_src = 32'h0000_5008; d_dst = 32'h0000_6000; d_sstep = 16'd4; d_dstep = 16'd4;
    d_ssz = 3'd2; d_dsz = 3'd2; d_smod = 5'd4; d_dmod = 5'd0; d_nbytes = 16'd16;
    d_iter = 15'd1; d_lofs_s = 1'b0; d_lofs_d = 1'b0; d_slast = 32'd0; d_dlast = 32'd0;
    d_lmode = 2'd0; d_bw = 2'd3; d_astop = 1'b1; d_ime = 1'b1;
    load_desc();
    run_pass(1'b1, 1'b0);   // R5 wrap, R12 auto-stop clears enable
    begin : ignored_req
      logic [AW-1:0] s0;
      logic [CW-1:0] i0;
      bit seen_busy;
      s0 = src_now; i0 = iter_now; seen_busy = 1'b0;
      @(negedge clk) hw_req = 1'b1;
      @(negedge clk) hw_req = 1'b0;
      for (int k = 0; k < 12; k++) begin
        if (busy) seen_busy = 1'b1;
        @(negedge clk);
      end
      check(!seen_busy, "R2", "hw_req ignored when disabled", 64'(seen_busy), 64'd0);
      check(src_now == s0 && iter_now == i0, "R2", "state untouched by ignored request",
            64'(src_now), 64'(s0));
    end

    // Case D: 32-byte elements, code 1 no throttle, link mode 3 none, half disabled
    d_src = 32'h0000_8000; d_dst = 32'h0000_9000; d_sstep = 16'd32; d_dstep = 16'd32;
    d_ssz = 3'd5; d_dsz = 3'd5; d_smod = 5'd0; d_nbytes = 16'd64; d_iter = 15'd2;
    d_bw = 2'd1; d_lmode = 2'd3; d_ihe = 1'b0; d_ime = 1'b0; d_astop = 1'b0;
    d_slast = -32'sd128; d_dlast = -32'sd128;
    load_desc();
    run_pass(1'b0, 1'b0);   // R9 code 1 gives no gaps, R11 half disabled
    run_pass(1'b0, 1'b0);   // R10 mode 3 never links

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule